// File: doc/BRIEF.md
# Chained Serial Display Driver Loader

This controller sits between a host and a chain of one or more 32-stage shift-then-latch output drivers, such as those that feed a multiplexed vacuum-fluorescent display. The host offers a whole chain-width frame word on a valid/ready handshake. The controller then serializes the word onto a data line and a shift clock. It waits out a clock-to-latch gap, pulses the latch line, and reports completion with a one-cycle done pulse.

Every driver timing minimum is given in nanoseconds, together with the system clock period. Each minimum is turned into a whole number of system cycles, always rounded up. The timed minimums are data setup, data hold, clock high width, the gap from the last clock to the latch, and the latch width.

A per-frame blanking option holds the drivers' outputs dark while the chain contents are being replaced. This supports inter-digit multiplexing.

Back-pressure works as follows:
- `frame_ready` is high only while the controller is idle.
- A frame transfers on a cycle where both `frame_valid` and `frame_ready` are high.
- `frame_valid` seen while `frame_ready` is low has no effect. The host must hold the word until the transfer, or offer it again later.

Top module: `vfd_chain_loader`

## Requirements
- R1: `frame_ready` is high exactly when `busy` is low. A frame and the `auto_blank` setting are captured only on a cycle with `frame_valid` and `frame_ready` both high. `frame_valid` or `frame_word` activity while busy does not change what gets latched, and starts no further sequence.
- R2: Each accepted frame produces exactly N_DEV*DEV_BITS rising edges of `drv_clk`. Word bit FRAME_W-1 is sent first and bit 0 last, so the first chain stage ends up holding bit 0 and the most distant stage holds bit FRAME_W-1.
- R3: `drv_data` is unchanged for at least SETUP cycles before every rising `drv_clk` edge.
- R4: `drv_data` stays unchanged for at least HOLD cycles after every rising `drv_clk` edge. Each `drv_clk` high pulse lasts at least CLKHI cycles.
- R5: At least GAP cycles separate the last rising `drv_clk` edge of a frame from the rising edge of `drv_latch`. `drv_clk` and `drv_latch` are never high together.
- R6: `drv_latch` is high for one pulse per frame, of at least STB cycles.
- R7: Each cycle count is ceil(min_ns / SYS_CLK_NS), with a minimum of 1. The clock high pulse lasts exactly max(CLKHI, HOLD) cycles, and the latch pulse lasts exactly STB cycles.
- R8: If `auto_blank` was high at acceptance, `drv_blank` rises one cycle before the first clock's setup interval starts. It stays high through the latch pulse and the done cycle, and is low on the cycle after done.
- R9: If `auto_blank` was low at acceptance, `drv_blank` stays low for the whole frame.
- R10: `done` is high for exactly one cycle per frame. That cycle immediately follows the cycle in which `drv_latch` was last high, and `busy` is still high during it.
- R11: After reset, `drv_data`, `drv_clk`, `drv_latch`, `drv_blank`, `busy` and `done` are low, and `frame_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_blank | input | 1 | Blank the drivers around this frame; sampled at acceptance |
| frame_valid | input | 1 | Host offers a frame |
| frame_ready | output | 1 | Controller can take a frame (idle) |
| frame_word | input | N_DEV*DEV_BITS | Frame contents; bit i drives chain output i |
| busy | output | 1 | A frame sequence is in progress |
| done | output | 1 | One-cycle pulse when the latch has completed |
| drv_data | output | 1 | Serial data to the first driver |
| drv_clk | output | 1 | Shift clock to all drivers |
| drv_latch | output | 1 | Latch (transfer) pulse to all drivers |
| drv_blank | output | 1 | Output blanking to all drivers, high = dark |

## Verification
The embedded assertions assume that the host respects the handshake and that reset is applied before the first transfer. Beyond that, they assume nothing about the frame word, so any bit pattern is legal.

The bench keeps within these assumptions by offering frames only at a negative clock edge while `frame_ready` is high, and by dropping `frame_valid` right after the transfer. In the one deliberate exception, it raises `frame_valid` with a different word mid-sequence to show that the offer is ignored.

A reduced two-device, four-stage chain allows every 8-bit word to be swept in both blanking settings.

// File: rtl/vfdl_pkg.sv
package vfdl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_HIGH   = 3'd3,
    ST_GAP    = 3'd4,
    ST_STROBE = 3'd5,
    ST_TAIL   = 3'd6
  } seq_state_e;

  // Whole system cycles covering a minimum time, never fewer than one.
  function automatic int ns_to_cycles(input int min_ns, input int clk_ns);
    int c;
    c = (min_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vfdl_phase_timer.sv
module vfdl_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R7: a reload sets the remaining phase length to the requested count
  assert_timer_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/vfdl_frame_shifter.sv
module vfdl_frame_shifter #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_word,
  input  logic          advance,
  output logic          ser_bit
);

  logic [FW-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        sr_q <= '0;
    else if (load)     sr_q <= load_word;
    else if (advance)  sr_q <= {sr_q[FW-2:0], 1'b0};
  end

  // R2: the highest-numbered bit leaves first
  assign ser_bit = sr_q[FW-1];

  // R2: after a load the serial line presents the top word bit
  assert_first_bit_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ser_bit == $past(load_word[FW-1])));

endmodule

// File: rtl/vfdl_sequencer.sv
module vfdl_sequencer
  import vfdl_pkg::*;
#(
  parameter int FW      = 32,
  parameter int TW      = 4,
  parameter int SETUP_C = 1,
  parameter int HIGH_C  = 1,
  parameter int GAP_C   = 1,
  parameter int STB_C   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_valid,
  input  logic          auto_blank,
  input  logic          tmr_expired,
  input  logic          ser_bit,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          shf_load,
  output logic          shf_adv,
  output logic          frame_ready,
  output logic          busy,
  output logic          done,
  output logic          drv_clk,
  output logic          drv_latch,
  output logic          drv_blank
);

  localparam int BW = $clog2(FW + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);
  localparam logic [TW-1:0] SETUP_V = TW'(SETUP_C - 1);
  localparam logic [TW-1:0] HIGH_V  = TW'(HIGH_C - 1);
  localparam logic [TW-1:0] GAP_V   = TW'(GAP_C - 1);
  localparam logic [TW-1:0] STB_V   = TW'(STB_C - 1);

  seq_state_e    state_q, state_n;
  logic [BW-1:0] bit_q, bit_n;
  logic          auto_q, clk_q, latch_q, blank_q, done_q;
  logic          accept;

  assign accept      = (state_q == ST_IDLE) && frame_valid;
  assign frame_ready = (state_q == ST_IDLE);
  assign busy        = (state_q != ST_IDLE);

  always_comb begin
    state_n  = state_q;
    bit_n    = bit_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    shf_load = 1'b0;
    shf_adv  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (frame_valid) begin
        shf_load = 1'b1;
        bit_n    = '0;
        tmr_load = 1'b1;
        tmr_val  = SETUP_V;
        state_n  = auto_blank ? ST_LEAD : ST_SETUP;
      end
      ST_LEAD: begin
        tmr_load = 1'b1;
        tmr_val  = SETUP_V;
        state_n  = ST_SETUP;
      end
      ST_SETUP: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = HIGH_V;
        state_n  = ST_HIGH;
      end
      ST_HIGH: if (tmr_expired) begin
        shf_adv  = 1'b1;
        tmr_load = 1'b1;
        if (bit_q == LAST_BIT) begin
          tmr_val = GAP_V;
          state_n = ST_GAP;
        end else begin
          tmr_val = SETUP_V;
          bit_n   = bit_q + 1'b1;
          state_n = ST_SETUP;
        end
      end
      ST_GAP: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = STB_V;
        state_n  = ST_STROBE;
      end
      ST_STROBE: if (tmr_expired) state_n = ST_TAIL;
      ST_TAIL:   state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      auto_q  <= 1'b0;
      clk_q   <= 1'b0;
      latch_q <= 1'b0;
      blank_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      clk_q   <= (state_n == ST_HIGH);
      latch_q <= (state_n == ST_STROBE);
      done_q  <= (state_n == ST_TAIL);
      if (accept) begin
        auto_q  <= auto_blank;
        blank_q <= auto_blank;
      end else if (state_q == ST_TAIL) begin
        blank_q <= 1'b0;
      end
    end
  end

  assign drv_clk   = clk_q;
  assign drv_latch = latch_q;
  assign drv_blank = blank_q;
  assign done      = done_q;

  // R1: an accepted frame always starts a sequence on the next cycle
  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_ready) |=> busy);

  // R3: the serial line does not move on the cycle the shift clock rises
  assert_data_steady_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_clk) |-> $stable(ser_bit));

  // R5: shift clock and latch never overlap
  assert_clk_latch_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_clk && drv_latch));

  // R8: with blanking selected, the latch pulse happens while blanked
  assert_blank_over_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_latch && auto_q) |-> drv_blank);

  // R9: without blanking selected, the blank line stays low
  assert_no_blank_manual_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !auto_q) |-> !drv_blank);

  // R10: done directly follows the end of the latch pulse
  assert_done_after_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(drv_latch) && !drv_latch && busy));

endmodule

// File: rtl/vfd_chain_loader.sv
module vfd_chain_loader
  import vfdl_pkg::*;
#(
  parameter int N_DEV        = 1,
  parameter int DEV_BITS     = 32,
  parameter int SYS_CLK_NS   = 20,
  parameter int MIN_SETUP_NS = 25,
  parameter int MIN_HOLD_NS  = 25,
  parameter int MIN_CLKHI_NS = 50,
  parameter int MIN_C2L_NS   = 100,
  parameter int MIN_LATCH_NS = 50,
  localparam int FRAME_W     = N_DEV * DEV_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_blank,
  input  logic               frame_valid,
  output logic               frame_ready,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               busy,
  output logic               done,
  output logic               drv_data,
  output logic               drv_clk,
  output logic               drv_latch,
  output logic               drv_blank
);

  localparam int SETUP_C = ns_to_cycles(MIN_SETUP_NS, SYS_CLK_NS);
  localparam int HIGH_C  = max2(ns_to_cycles(MIN_CLKHI_NS, SYS_CLK_NS),
                                ns_to_cycles(MIN_HOLD_NS, SYS_CLK_NS));
  localparam int GAP_C   = ns_to_cycles(MIN_C2L_NS, SYS_CLK_NS);
  localparam int STB_C   = ns_to_cycles(MIN_LATCH_NS, SYS_CLK_NS);
  localparam int MAX_C   = max2(max2(SETUP_C, HIGH_C), max2(GAP_C, STB_C));
  localparam int TW      = $clog2(MAX_C + 1);

  logic          tmr_load, tmr_expired, shf_load, shf_adv, ser_bit;
  logic [TW-1:0] tmr_val;

  vfdl_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  vfdl_frame_shifter #(.FW(FRAME_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (shf_load),
    .load_word (frame_word),
    .advance   (shf_adv),
    .ser_bit   (ser_bit)
  );

  vfdl_sequencer #(
    .FW(FRAME_W), .TW(TW), .SETUP_C(SETUP_C), .HIGH_C(HIGH_C),
    .GAP_C(GAP_C), .STB_C(STB_C)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .auto_blank  (auto_blank),
    .tmr_expired (tmr_expired),
    .ser_bit     (ser_bit),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .shf_load    (shf_load),
    .shf_adv     (shf_adv),
    .frame_ready (frame_ready),
    .busy        (busy),
    .done        (done),
    .drv_clk     (drv_clk),
    .drv_latch   (drv_latch),
    .drv_blank   (drv_blank)
  );

  assign drv_data = ser_bit;

endmodule

// File: tb/vfd_chain_loader_tb.sv
module vfd_chain_loader_tb;

  localparam int ND = 2, DB = 4, FW = ND * DB, CLKNS = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLKNS - 1) / CLKNS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SU_C  = cyc(25);
  localparam int HO_C  = cyc(25);
  localparam int HI_C  = (cyc(50) > cyc(25)) ? cyc(50) : cyc(25);
  localparam int GAP_C = cyc(100);
  localparam int STB_C = cyc(50);

  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_blank = 1'b0, frame_valid = 1'b0;
  logic [FW-1:0] frame_word = '0;
  logic frame_ready, busy, done, drv_data, drv_clk, drv_latch, drv_blank;

  int errors = 0, checks = 0, cycles = 0;

  vfd_chain_loader #(.N_DEV(ND), .DEV_BITS(DB), .SYS_CLK_NS(CLKNS)) u_dut (
    .clk(clk), .rst_n(rst_n), .auto_blank(auto_blank),
    .frame_valid(frame_valid), .frame_ready(frame_ready), .frame_word(frame_word),
    .busy(busy), .done(done), .drv_data(drv_data), .drv_clk(drv_clk),
    .drv_latch(drv_latch), .drv_blank(drv_blank)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver-chain model and timing monitor
  logic [FW-1:0] chain_m = '0, latch_m = '0;
  int  rises = 0;
  bit  cur_auto = 0;
  logic p_data = 0, p_clk = 0, p_latch = 0, p_done = 0;
  int  stable_cnt = 0, since_rise = 1000, hi_run = 0, stb_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (drv_clk && !p_clk) begin
        chk((drv_data == p_data) && (stable_cnt >= SU_C), "R3 setup", stable_cnt, SU_C);
        chain_m = {chain_m[FW-2:0], drv_data};
        rises++;
      end
      if (drv_data != p_data)
        chk(since_rise >= HO_C, "R4 hold", since_rise, HO_C);
      if (drv_clk) hi_run++;
      if (!drv_clk && p_clk) begin
        chk(hi_run == HI_C, "R4 R7 clock high width", hi_run, HI_C);
        hi_run = 0;
      end
      if (drv_latch && !p_latch) begin
        chk(since_rise >= GAP_C, "R5 clock to latch gap", since_rise, GAP_C);
        chk(!drv_clk, "R5 clock low at latch", drv_clk, 0);
      end
      if (drv_latch) begin
        stb_run++;
        latch_m = chain_m;
      end
      if (!drv_latch && p_latch) begin
        chk(stb_run == STB_C, "R6 R7 latch width", stb_run, STB_C);
        stb_run = 0;
      end
      if (drv_clk || drv_latch)
        chk(drv_blank == cur_auto, cur_auto ? "R8 blank during update" : "R9 blank stays low",
            drv_blank, cur_auto);
      if (done) begin
        chk(!drv_latch && p_latch && busy, "R10 done after latch", p_latch, 1);
        chk(!p_done, "R10 done one cycle", p_done, 0);
        chk(drv_blank == cur_auto, cur_auto ? "R8 blank at done" : "R9 blank at done",
            drv_blank, cur_auto);
      end
      if (p_done)
        chk(!drv_blank && !busy && !done, "R8 R10 release after done", drv_blank, 0);
      chk(frame_ready == !busy, "R1 ready mirrors idle", frame_ready, !busy);
      stable_cnt = (drv_data != p_data) ? 1 : stable_cnt + 1;
      since_rise = (drv_clk && !p_clk) ? 1 : since_rise + 1;
      p_data = drv_data; p_clk = drv_clk; p_latch = drv_latch; p_done = done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R10 done reached", done, 1);
  endtask

  task automatic send(input logic [FW-1:0] w, input bit ab);
    while (!frame_ready) @(negedge clk);
    rises = 0;
    cur_auto = ab;
    auto_blank = ab; frame_word = w; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    auto_blank = 1'b0;
    if (ab) chk(drv_blank && !drv_clk, "R8 blank leads data", drv_blank, 1);
    wait_done();
    chk(latch_m == w, "R2 latched word", latch_m, w);
    chk(rises == FW, "R2 clock count", rises, FW);
    @(negedge clk);
  endtask

  initial begin
    logic [FW-1:0] w1;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!drv_data && !drv_clk && !drv_latch && !drv_blank && !busy && !done && frame_ready,
        "R11 reset state", {drv_data, drv_clk, drv_latch, drv_blank, busy, done, frame_ready}, 1);

    // R2 R8 R9: every word in both blanking settings
    for (int ab = 0; ab < 2; ab++)
      for (int w = 0; w < (1 << FW); w++)
        send(FW'(w), ab[0]);

    // R1: an offer made while busy is ignored
    w1 = 8'hA5;
    rises = 0; cur_auto = 1'b1;
    auto_blank = 1'b1; frame_word = w1; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0; auto_blank = 1'b0;
    repeat (6) @(negedge clk);
    chk(!frame_ready && busy, "R1 not ready while busy", frame_ready, 0);
    frame_word = ~w1; frame_valid = 1'b1;
    repeat (5) @(negedge clk);
    frame_valid = 1'b0;
    wait_done();
    chk(latch_m == w1, "R1 busy offer ignored", latch_m, w1);
    r0 = rises;
    repeat (8) @(negedge clk);
    chk(!busy && rises == r0, "R1 no extra sequence", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule